// File: doc/BRIEF.md
# DMA Channel Request and Block-Length Controller

This block is the request front end of a single DMA channel. It decides when a read transaction may start on the source side and when a write transaction may start on the destination side. It also decides when the block ends. Data moves from the source into a channel FIFO and from there out to the destination. The FIFO storage, the bus protocol and address generation all live elsewhere; only occupancy bookkeeping for start decisions is kept here.

Each side is programmed independently as one of four kinds:

- memory, which is always ready;
- a hardware handshake, with a request line, a single/burst select and a last flag;
- a software handshake, where a request is posted by a one-cycle write strobe;
- an interrupt-driven handshake, where the peripheral's interrupt line acts as the request.

A separate selector names the party that terminates the block:

- the DMA itself, counting a programmed length;
- the source peripheral, through its last flag;
- the destination peripheral, through its last flag.

When the destination terminates the block, an optional prefetch limit holds back source reads until the destination has actually asked for data. The transaction engine reports completion of each started read or write with a one-cycle done pulse. At most one read and one write are outstanding at any time.

Top module: `dma_chan_reqctl`

## Requirements
- R1: While `rst` is high or `ch_en` is low, `rd_start` and `wr_start` stay low. All channel state is cleared, so `blk_done` reads 0 one cycle after `ch_en` falls.
- R2: A side with kind code 0 (memory) is always ready with burst-sized requests and never raises its acknowledge.
- R3: For kind code 1 (hardware), `*_hw_req` requests a transfer, and `*_hw_single`=1 selects one item instead of a burst. The side acknowledge is high in the same cycle as the done pulse of that side's transfer. The request line is ignored in the cycle after an acknowledge.
- R4: For kind code 3 (interrupt), the `*_irq` line is the request and the transfer is always a burst. The hardware request, single and last inputs have no effect.
- R5: For kind code 2 (software), a one-cycle `*_sw_req` strobe posts a request, with its size taken from `*_sw_single`. A read on the source side may start in the following cycle. The posted request is withdrawn when its transfer completes.
- R6: With `flow_sel`=0 (DMA ends the block), reads are bursts of BURST items while at least BURST items remain of `blk_len`, and single items after that. In total, exactly `blk_len` items are read.
- R7: A read starts only if the FIFO has room for its size, counting reads that are still in flight and data not yet written out.
- R8: A burst write (`wr_burst`=1, BURST items) needs at least BURST unclaimed items in the FIFO. Once reading has ended, with no read in flight, remaining items are written as single transfers.
- R9: With `flow_sel`=1, a source request carrying its last flag makes that read the final one. `blk_done` rises once the written data has drained.
- R10: With `flow_sel`=2, a destination request carrying its last flag makes that write the final one. `blk_done` rises in the cycle after that write completes.
- R11: With `flow_sel`=2 and `pf_limit`=1, reads start only while the destination has a request pending and the FIFO holds fewer items than that request needs. With `pf_limit`=0, reads run ahead up to the FIFO size.
- R12: A read or write start is never followed by another start of the same kind in the next cycle. Once `blk_done` is high, no start occurs, and it stays high until `ch_en` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 1 | Channel enable; low clears channel state |
| src_kind | input | 2 | Source kind: 0 memory, 1 hardware, 2 software, 3 interrupt |
| dst_kind | input | 2 | Destination kind, same encoding |
| flow_sel | input | 2 | Block terminator: 0 DMA, 1 source, 2 destination, 3 as 0 |
| pf_limit | input | 1 | Prefetch limit when the destination ends the block |
| blk_len | input | LEN_W | Block length in items when the DMA ends the block |
| src_hw_req | input | 1 | Source hardware request |
| src_hw_single | input | 1 | Source hardware size select, 1 = single |
| src_hw_last | input | 1 | Source hardware last flag |
| src_irq | input | 1 | Source interrupt line used as request |
| src_sw_req | input | 1 | Source software request strobe |
| src_sw_single | input | 1 | Source software size select |
| src_sw_last | input | 1 | Source software last flag |
| dst_hw_req | input | 1 | Destination hardware request |
| dst_hw_single | input | 1 | Destination hardware size select |
| dst_hw_last | input | 1 | Destination hardware last flag |
| dst_irq | input | 1 | Destination interrupt line used as request |
| dst_sw_req | input | 1 | Destination software request strobe |
| dst_sw_single | input | 1 | Destination software size select |
| dst_sw_last | input | 1 | Destination software last flag |
| rd_done | input | 1 | Started read has completed |
| wr_done | input | 1 | Started write has completed |
| rd_start | output | 1 | Start a read transaction this cycle |
| rd_burst | output | 1 | Read size: 1 = BURST items, 0 = one item |
| wr_start | output | 1 | Start a write transaction this cycle |
| wr_burst | output | 1 | Write size: 1 = BURST items, 0 = one item |
| src_ack | output | 1 | Acknowledge to source handshake |
| dst_ack | output | 1 | Acknowledge to destination handshake |
| blk_done | output | 1 | Block complete, held until ch_en falls |

## Verification
The checker assumes that `rd_done` and `wr_done` arrive only for a transaction that is actually in flight, and never in the same cycle as its start. It also assumes that kind, flow and length settings change only while `ch_en` is low, and that `blk_len` is at least 1 under DMA flow control. The bench's transaction model returns each done pulse exactly two cycles after the start it observed. Every scenario begins with the channel disabled for several cycles, so no stray done pulse leaks into the next configuration. Hardware request lines are held steady across a test and are changed only at falling clock edges.

// File: rtl/dma_rq_pkg.sv
`timescale 1ns/1ps
package dma_rq_pkg;

    typedef enum logic [1:0] {
        SK_MEM = 2'd0,
        SK_HW  = 2'd1,
        SK_SW  = 2'd2,
        SK_IRQ = 2'd3
    } side_kind_e;

    typedef enum logic [1:0] {
        FC_DMA  = 2'd0,
        FC_SRC  = 2'd1,
        FC_DST  = 2'd2,
        FC_RSVD = 2'd3
    } flow_e;

    typedef struct packed {
        logic valid;
        logic single;
        logic last;
    } hs_req_t;

    function automatic logic kind_acks(side_kind_e k);
        return (k == SK_HW) || (k == SK_IRQ);
    endfunction

endpackage

// File: rtl/dma_hs_side.sv
`timescale 1ns/1ps
module dma_hs_side
    import dma_rq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  side_kind_e kind,
    input  logic       hw_req,
    input  logic       hw_single,
    input  logic       hw_last,
    input  logic       irq,
    input  logic       sw_req,
    input  logic       sw_single,
    input  logic       sw_last,
    input  logic       xfer_done,
    output hs_req_t    req,
    output logic       ack
);

    logic sw_pend, sw_sng, sw_lst, hold;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sw_pend <= 1'b0;
            sw_sng  <= 1'b0;
            sw_lst  <= 1'b0;
            hold    <= 1'b0;
        end else begin
            if (sw_req && kind == SK_SW) begin
                sw_pend <= 1'b1;
                sw_sng  <= sw_single;
                sw_lst  <= sw_last;
            end else if (xfer_done) begin
                sw_pend <= 1'b0;
            end
            hold <= ack;
        end
    end

    always_comb begin
        ack = xfer_done && en && kind_acks(kind);
        req = '0;
        unique case (kind)
            SK_MEM: req = '{valid: 1'b1, single: 1'b0, last: 1'b0};
            SK_HW:  req = '{valid: hw_req && !hold, single: hw_single, last: hw_last};
            SK_SW:  req = '{valid: sw_pend, single: sw_sng, last: sw_lst};
            SK_IRQ: req = '{valid: irq && !hold, single: 1'b0, last: 1'b0};
            default: req = '0;
        endcase
    end

endmodule

// File: rtl/dma_fifo_acct.sv
`timescale 1ns/1ps
module dma_fifo_acct #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          rd_start,
    input  logic [CW-1:0] rd_sz,
    input  logic          rd_done,
    input  logic          wr_start,
    input  logic [CW-1:0] wr_sz,
    input  logic          wr_done,
    output logic [CW-1:0] avail,
    output logic [CW-1:0] room
);

    logic [CW-1:0] rd_fly, wr_fly;
    logic [CW-1:0] add_av, sub_av, add_rm, sub_rm;

    always_comb begin
        add_av = rd_done  ? rd_fly : '0;
        sub_av = wr_start ? wr_sz  : '0;
        add_rm = wr_done  ? wr_fly : '0;
        sub_rm = rd_start ? rd_sz  : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            avail  <= '0;
            room   <= CW'(DEPTH);
            rd_fly <= '0;
            wr_fly <= '0;
        end else begin
            if (rd_start) rd_fly <= rd_sz;
            if (wr_start) wr_fly <= wr_sz;
            avail <= avail + add_av - sub_av;
            room  <= room + add_rm - sub_rm;
        end
    end

endmodule

// File: rtl/dma_blk_ctl.sv
`timescale 1ns/1ps
module dma_blk_ctl
    import dma_rq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BURST = 4,
    parameter int LEN_W = 12,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  flow_e            flow,
    input  logic             pf_limit,
    input  logic [LEN_W-1:0] blk_len,
    input  hs_req_t          src_req,
    input  hs_req_t          dst_req,
    input  logic [CW-1:0]    avail,
    input  logic [CW-1:0]    room,
    input  logic             rd_done,
    input  logic             wr_done,
    output logic             rd_start,
    output logic             rd_burst,
    output logic [CW-1:0]    rd_sz,
    output logic             wr_start,
    output logic             wr_burst,
    output logic [CW-1:0]    wr_sz,
    output logic             blk_done
);

    localparam logic [CW-1:0] BURST_C = CW'(BURST);
    localparam logic [CW-1:0] ONE_C   = CW'(1);

    logic go, dma_fc, src_fc, dst_fc;
    logic rd_busy, wr_busy, rd_end, wr_last_fly, done_r;
    logic [LEN_W-1:0] rd_cnt, rd_rem;
    logic [LEN_W:0]   rd_after;
    logic rd_small, pf_ok, flush, wr_ok, rd_end_now, drained;
    logic [CW-1:0] dst_need;

    always_comb begin
        go     = en && !rst;
        src_fc = (flow == FC_SRC);
        dst_fc = (flow == FC_DST);
        dma_fc = !src_fc && !dst_fc;

        // read sizing and gating
        rd_rem   = blk_len - rd_cnt;
        rd_small = src_req.single || (dma_fc && (rd_rem < LEN_W'(BURST)));
        rd_sz    = rd_small ? ONE_C : BURST_C;
        rd_burst = !rd_small;
        dst_need = dst_req.single ? ONE_C : BURST_C;
        pf_ok    = !(dst_fc && pf_limit) || (dst_req.valid && (avail < dst_need));
        rd_start = go && !done_r && !rd_busy && !rd_end && src_req.valid
                   && (room >= rd_sz) && pf_ok;
        rd_after = {1'b0, rd_cnt} + (LEN_W+1)'(rd_sz);
        rd_end_now = (dma_fc && (rd_after >= {1'b0, blk_len})) || (src_fc && src_req.last);

        // write sizing and gating
        flush    = rd_end && !rd_busy && !dst_fc;
        wr_burst = !dst_req.single && (avail >= BURST_C);
        wr_sz    = wr_burst ? BURST_C : ONE_C;
        wr_ok    = dst_req.valid && (avail != '0)
                   && (dst_req.single || (avail >= BURST_C) || flush);
        wr_start = go && !done_r && !wr_busy && wr_ok;

        drained  = rd_end && !rd_busy && (avail == '0) && (!wr_busy || wr_done);
        blk_done = done_r;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            rd_busy     <= 1'b0;
            wr_busy     <= 1'b0;
            rd_end      <= 1'b0;
            wr_last_fly <= 1'b0;
            done_r      <= 1'b0;
            rd_cnt      <= '0;
        end else begin
            if (rd_start) begin
                rd_busy <= 1'b1;
                rd_cnt  <= rd_after[LEN_W-1:0];
                if (rd_end_now) rd_end <= 1'b1;
            end else if (rd_done) begin
                rd_busy <= 1'b0;
            end

            if (wr_start) begin
                wr_busy     <= 1'b1;
                wr_last_fly <= dst_req.last;
                if (dst_fc && dst_req.last) rd_end <= 1'b1;
            end else if (wr_done) begin
                wr_busy <= 1'b0;
            end

            if (dst_fc) begin
                if (wr_done && wr_last_fly) done_r <= 1'b1;
            end else if (drained) begin
                done_r <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_chan_reqctl.sv
`timescale 1ns/1ps
module dma_chan_reqctl
    import dma_rq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BURST = 4,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ch_en,
    input  logic [1:0]       src_kind,
    input  logic [1:0]       dst_kind,
    input  logic [1:0]       flow_sel,
    input  logic             pf_limit,
    input  logic [LEN_W-1:0] blk_len,
    input  logic             src_hw_req,
    input  logic             src_hw_single,
    input  logic             src_hw_last,
    input  logic             src_irq,
    input  logic             src_sw_req,
    input  logic             src_sw_single,
    input  logic             src_sw_last,
    input  logic             dst_hw_req,
    input  logic             dst_hw_single,
    input  logic             dst_hw_last,
    input  logic             dst_irq,
    input  logic             dst_sw_req,
    input  logic             dst_sw_single,
    input  logic             dst_sw_last,
    input  logic             rd_done,
    input  logic             wr_done,
    output logic             rd_start,
    output logic             rd_burst,
    output logic             wr_start,
    output logic             wr_burst,
    output logic             src_ack,
    output logic             dst_ack,
    output logic             blk_done
);

    localparam int CW = $clog2(DEPTH + 1);

    hs_req_t       src_req, dst_req;
    logic [CW-1:0] avail, room, rd_sz, wr_sz;

    dma_hs_side u_src_side (
        .clk       (clk),
        .rst       (rst),
        .en        (ch_en),
        .kind      (side_kind_e'(src_kind)),
        .hw_req    (src_hw_req),
        .hw_single (src_hw_single),
        .hw_last   (src_hw_last),
        .irq       (src_irq),
        .sw_req    (src_sw_req),
        .sw_single (src_sw_single),
        .sw_last   (src_sw_last),
        .xfer_done (rd_done),
        .req       (src_req),
        .ack       (src_ack)
    );

    dma_hs_side u_dst_side (
        .clk       (clk),
        .rst       (rst),
        .en        (ch_en),
        .kind      (side_kind_e'(dst_kind)),
        .hw_req    (dst_hw_req),
        .hw_single (dst_hw_single),
        .hw_last   (dst_hw_last),
        .irq       (dst_irq),
        .sw_req    (dst_sw_req),
        .sw_single (dst_sw_single),
        .sw_last   (dst_sw_last),
        .xfer_done (wr_done),
        .req       (dst_req),
        .ack       (dst_ack)
    );

    dma_fifo_acct #(.DEPTH(DEPTH), .CW(CW)) u_acct (
        .clk      (clk),
        .rst      (rst),
        .en       (ch_en),
        .rd_start (rd_start),
        .rd_sz    (rd_sz),
        .rd_done  (rd_done),
        .wr_start (wr_start),
        .wr_sz    (wr_sz),
        .wr_done  (wr_done),
        .avail    (avail),
        .room     (room)
    );

    dma_blk_ctl #(.DEPTH(DEPTH), .BURST(BURST), .LEN_W(LEN_W), .CW(CW)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .en       (ch_en),
        .flow     (flow_e'(flow_sel)),
        .pf_limit (pf_limit),
        .blk_len  (blk_len),
        .src_req  (src_req),
        .dst_req  (dst_req),
        .avail    (avail),
        .room     (room),
        .rd_done  (rd_done),
        .wr_done  (wr_done),
        .rd_start (rd_start),
        .rd_burst (rd_burst),
        .rd_sz    (rd_sz),
        .wr_start (wr_start),
        .wr_burst (wr_burst),
        .wr_sz    (wr_sz),
        .blk_done (blk_done)
    );

endmodule

// File: rtl/dma_chan_reqctl_chk.sv
`timescale 1ns/1ps
module dma_chan_reqctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ch_en,
    input logic [1:0] src_kind,
    input logic [1:0] dst_kind,
    input logic [1:0] flow_sel,
    input logic       pf_limit,
    input logic       dst_hw_req,
    input logic       rd_start,
    input logic       wr_start,
    input logic       src_ack,
    input logic       dst_ack,
    input logic       blk_done
);

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !ch_en |-> (!rd_start && !wr_start)); // R1

    AST_MEM_SRC_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (src_kind == 2'd0) |-> !src_ack); // R2

    AST_MEM_DST_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (dst_kind == 2'd0) |-> !dst_ack); // R2

    AST_ACK_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
        src_ack |=> !rd_start); // R3

    AST_PREFETCH_HELD: assert property (@(posedge clk) disable iff (rst)
        (flow_sel == 2'd2 && pf_limit && dst_kind == 2'd1 && !dst_hw_req) |-> !rd_start); // R11

    AST_ONE_RD_OUT: assert property (@(posedge clk) disable iff (rst)
        rd_start |=> !rd_start); // R12

    AST_ONE_WR_OUT: assert property (@(posedge clk) disable iff (rst)
        wr_start |=> !wr_start); // R12

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        blk_done |-> (!rd_start && !wr_start)); // R12

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (blk_done && ch_en) |=> blk_done); // R12

endmodule

bind dma_chan_reqctl dma_chan_reqctl_chk u_chk (.*);

// File: tb/dma_chan_reqctl_tb_top.sv
`timescale 1ns/1ps
module dma_chan_reqctl_tb_top;

    localparam int DEPTH = 16;
    localparam int BURST = 4;
    localparam int LEN_W = 12;
    localparam int NTBL  = 8;
    // {blk_len, read bursts, read singles, write bursts, write singles}
    localparam int TBL [NTBL][5] = '{
        '{8, 2, 0, 2, 0}, '{10, 2, 2, 2, 2}, '{3, 0, 3, 0, 3}, '{4, 1, 0, 1, 0},
        '{13, 3, 1, 3, 1}, '{1, 0, 1, 0, 1}, '{16, 4, 0, 4, 0}, '{6, 1, 2, 1, 2}
    };

    logic clk = 1'b0;
    logic rst, ch_en, pf_limit;
    logic [1:0] src_kind, dst_kind, flow_sel;
    logic [LEN_W-1:0] blk_len;
    logic src_hw_req, src_hw_single, src_hw_last, src_irq, src_sw_req, src_sw_single, src_sw_last;
    logic dst_hw_req, dst_hw_single, dst_hw_last, dst_irq, dst_sw_req, dst_sw_single, dst_sw_last;
    logic rd_done, wr_done;
    logic rd_start, rd_burst, wr_start, wr_burst, src_ack, dst_ack, blk_done;

    int n_chk = 0, n_fail = 0;
    int rd_tmr = 0, wr_tmr = 0;
    int n_rd_b = 0, n_rd_s = 0, n_wr_b = 0, n_wr_s = 0, n_src_ack = 0, n_dst_ack = 0;
    logic clr_cnt = 1'b0;

    always #2.5 clk = ~clk;

    dma_chan_reqctl #(.DEPTH(DEPTH), .BURST(BURST), .LEN_W(LEN_W)) dut_i (.*);

    // transaction model: done two cycles after each start
    always_comb begin
        rd_done = (rd_tmr == 1);
        wr_done = (wr_tmr == 1);
    end

    always @(posedge clk) begin
        rd_tmr <= rd_start ? 2 : (rd_tmr > 0 ? rd_tmr - 1 : 0);
        wr_tmr <= wr_start ? 2 : (wr_tmr > 0 ? wr_tmr - 1 : 0);
        if (clr_cnt) begin
            n_rd_b <= 0; n_rd_s <= 0; n_wr_b <= 0; n_wr_s <= 0;
            n_src_ack <= 0; n_dst_ack <= 0;
        end else begin
            if (rd_start && rd_burst)  n_rd_b <= n_rd_b + 1;
            if (rd_start && !rd_burst) n_rd_s <= n_rd_s + 1;
            if (wr_start && wr_burst)  n_wr_b <= n_wr_b + 1;
            if (wr_start && !wr_burst) n_wr_s <= n_wr_s + 1;
            if (src_ack) n_src_ack <= n_src_ack + 1;
            if (dst_ack) n_dst_ack <= n_dst_ack + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic new_test();
        @(negedge clk);
        ch_en = 1'b0; pf_limit = 1'b0; flow_sel = 2'd0; blk_len = '0;
        src_kind = 2'd0; dst_kind = 2'd0;
        src_hw_req = 0; src_hw_single = 0; src_hw_last = 0; src_irq = 0;
        src_sw_req = 0; src_sw_single = 0; src_sw_last = 0;
        dst_hw_req = 0; dst_hw_single = 0; dst_hw_last = 0; dst_irq = 0;
        dst_sw_req = 0; dst_sw_single = 0; dst_sw_last = 0;
        cycles(5);
        clr_cnt = 1'b1;
        @(negedge clk);
        clr_cnt = 1'b0;
    endtask

    task automatic wait_done(input int max);
        for (int k = 0; k < max; k++) begin
            @(negedge clk);
            if (blk_done) break;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        finish_run();
    end

    initial begin
        rst = 1'b1; ch_en = 1'b1; pf_limit = 0; flow_sel = 0; blk_len = 12'd8;
        src_kind = 0; dst_kind = 0;
        src_hw_req = 0; src_hw_single = 0; src_hw_last = 0; src_irq = 0;
        src_sw_req = 0; src_sw_single = 0; src_sw_last = 0;
        dst_hw_req = 0; dst_hw_single = 0; dst_hw_last = 0; dst_irq = 0;
        dst_sw_req = 0; dst_sw_single = 0; dst_sw_last = 0;
        cycles(3); #1;
        chk("R1 rd_start in reset", int'(rd_start), 0);
        chk("R1 wr_start in reset", int'(wr_start), 0);
        chk("R1 blk_done in reset", int'(blk_done), 0);
        @(negedge clk); rst = 1'b0;

        // table: memory to memory, DMA ends the block
        for (int i = 0; i < NTBL; i++) begin
            new_test();
            blk_len = LEN_W'(TBL[i][0]);
            ch_en = 1'b1;
            wait_done(300);
            chk("R6 read bursts", n_rd_b, TBL[i][1]);
            chk("R6 read singles", n_rd_s, TBL[i][2]);
            chk("R8 write bursts", n_wr_b, TBL[i][3]);
            chk("R8 write singles", n_wr_s, TBL[i][4]);
            chk("R2 memory acks", n_src_ack + n_dst_ack, 0);
            cycles(5); #1;
            chk("R12 done held", int'(blk_done), 1);
            chk("R12 no start after done", n_rd_b + n_rd_s + n_wr_b + n_wr_s,
                TBL[i][1] + TBL[i][2] + TBL[i][3] + TBL[i][4]);
        end

        // R7: destination idle, reads stop when FIFO space is used up
        new_test();
        dst_kind = 2'd1; blk_len = 12'd40; ch_en = 1'b1;
        cycles(40);
        chk("R7 reads fill FIFO", n_rd_b, DEPTH / BURST);
        chk("R7 no singles", n_rd_s, 0);
        dst_hw_req = 1'b1;
        cycles(18);
        chk("R7 reads resume after writes", int'(n_rd_b > DEPTH / BURST), 1);

        // R11: prefetch limit
        new_test();
        flow_sel = 2'd2; pf_limit = 1'b1; dst_kind = 2'd1; ch_en = 1'b1;
        cycles(20);
        chk("R11 no read without dst request", n_rd_b + n_rd_s, 0);
        dst_hw_req = 1'b1;
        cycles(10);
        chk("R11 read on dst request", int'(n_rd_b > 0), 1);
        new_test();
        flow_sel = 2'd2; pf_limit = 1'b0; dst_kind = 2'd1; ch_en = 1'b1;
        cycles(20);
        chk("R11 read ahead with limit off", n_rd_b, DEPTH / BURST);

        // R3: hardware single requests, acknowledge and hold-off
        new_test();
        src_kind = 2'd1; src_hw_single = 1'b1; blk_len = 12'd2; ch_en = 1'b1;
        cycles(2);
        @(negedge clk); src_hw_req = 1'b1; #1;
        chk("R3 hw read start", int'(rd_start), 1);
        chk("R3 hw single size", int'(rd_burst), 0);
        @(negedge clk); #1;
        chk("R3 busy no start", int'(rd_start), 0);
        @(negedge clk); #1;
        chk("R3 ack with done", int'(src_ack), 1);
        @(negedge clk); #1;
        chk("R3 request ignored after ack", int'(rd_start), 0);
        @(negedge clk); #1;
        chk("R3 next request served", int'(rd_start), 1);
        src_hw_req = 1'b0;

        // R4: interrupt line as request
        new_test();
        src_kind = 2'd3; src_hw_req = 1'b1; src_hw_single = 1'b1; blk_len = 12'd8; ch_en = 1'b1;
        cycles(3); #1;
        chk("R4 hw_req ignored", int'(rd_start), 0);
        @(negedge clk); src_irq = 1'b1; #1;
        chk("R4 irq starts read", int'(rd_start), 1);
        chk("R4 irq is burst", int'(rd_burst), 1);
        cycles(3);
        chk("R4 irq ack", n_src_ack, 1);
        src_irq = 1'b0;

        // R5: software request strobe
        new_test();
        src_kind = 2'd2; blk_len = 12'd8; ch_en = 1'b1;
        cycles(3); #1;
        chk("R5 no start before strobe", int'(rd_start), 0);
        @(negedge clk); src_sw_req = 1'b1; src_sw_single = 1'b1;
        @(negedge clk); src_sw_req = 1'b0; #1;
        chk("R5 start after strobe", int'(rd_start), 1);
        chk("R5 single size", int'(rd_burst), 0);
        cycles(8);
        chk("R5 request withdrawn", n_rd_s + n_rd_b, 1);

        // R9: source ends the block
        new_test();
        src_kind = 2'd1; flow_sel = 2'd1; src_hw_req = 1'b1; src_hw_last = 1'b1; ch_en = 1'b1;
        wait_done(40);
        chk("R9 block done", int'(blk_done), 1);
        chk("R9 one read burst", n_rd_b, 1);
        chk("R9 one write burst", n_wr_b, 1);
        cycles(10);
        chk("R12 no read after done", n_rd_b + n_rd_s, 1);

        // R10: destination ends the block
        new_test();
        dst_kind = 2'd1; flow_sel = 2'd2; dst_hw_req = 1'b1; dst_hw_single = 1'b1;
        dst_hw_last = 1'b1; ch_en = 1'b1;
        wait_done(40);
        chk("R10 block done", int'(blk_done), 1);
        chk("R10 one single write", n_wr_s, 1);
        chk("R10 no burst write", n_wr_b, 0);

        // R1: disable clears state
        @(negedge clk); ch_en = 1'b0; dst_kind = 2'd0;
        @(negedge clk); #1;
        chk("R1 blk_done cleared", int'(blk_done), 0);
        chk("R1 no start when disabled", int'(rd_start), 0);
        chk("R1 no write when disabled", int'(wr_start), 0);

        finish_run();
    end

endmodule